// File: doc/BRIEF.md
# Dataflow Operand Matching Unit

This block sits at the front of a dataflow processing element and decides when an instruction may fire. Every incoming operand token is sorted by its 2-bit kind code. A single-operand token goes straight to the dispatch output.

A two-operand token is held in a matching store, addressed by its context slot and instruction offset, until its partner arrives. When the partner arrives, one dispatch packet goes out with the left and right operands in their proper places. A generation value travels with each two-operand token, and a partner with a different generation is not paired. Tokens of the two other kinds leave through a bypass output with every field unchanged.

A separate control request releases one context slot. It wipes every pending operand held for that slot and produces no output.

The input, dispatch and bypass streams all use valid/ready. A token is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when both the dispatch register and the bypass register are empty or are being emptied on that edge. `in_ready` does not depend on the token's kind.

On either output, a packet that is not yet accepted stays in place, unchanged, until its ready input is seen high. The free request, the stale counter and the error pulse are plain pins with no handshake.

Top module: `token_matcher`

## Requirements
- R1: After reset, `fire_valid`, `byp_valid` and `port_err` are 0 and `stale_count` is 0.
- R2: A kind-01 token that is accepted appears on the dispatch output on the next cycle. In that packet `fire_dyadic` is 0, `fire_left` is the token data and `fire_right` is 0, and ctx, offset and flag are copied from the token.
- R3: A kind-00 token whose (ctx, offset) entry is empty is stored and produces no output.
- R4: A kind-00 token that finds a stored entry with the same generation and the opposite port fires on the next cycle with `fire_dyadic` = 1. Port 0 data goes to `fire_left` and port 1 data goes to `fire_right`, whichever arrives first. The entry is then empty.
- R5: A kind-00 token that finds a stored entry with a different generation replaces that entry and does not fire. `stale_count` rises by 1 on the next cycle and saturates at its maximum.
- R6: A kind-00 token that finds a stored entry with the same generation and the same port replaces that entry and does not fire. `port_err` is high for exactly the next cycle.
- R7: A cycle with `free_req` high empties every entry of context `free_ctx` and produces no output. Entries of other contexts are kept. A kind-00 token for that context accepted in the same cycle sees an empty entry and is stored.
- R8: Tokens of kind 10 or 11 appear on the bypass output on the next cycle with every field unchanged, and nothing is stored or dispatched.
- R9: While an output holds a packet that its ready input has not taken, that packet stays unchanged and `in_ready` is 0.
- R10: On a two-operand dispatch, `fire_flag` is the flag of the token that completed the pair.
- R11: Entries at different (ctx, offset) addresses are independent. Every one of the 4 x 8 addresses pairs correctly for every generation value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be taken this cycle |
| in_type | input | 2 | Kind: 00 two-operand, 01 single-operand, 10/11 bypass |
| in_ctx | input | CTX_W | Context slot |
| in_offset | input | OFF_W | Instruction offset |
| in_port | input | 1 | 0 = left operand, 1 = right operand |
| in_gen | input | GEN_W | Generation value |
| in_flag | input | 1 | Inline/width flag |
| in_data | input | DATA_W | Operand word |
| free_req | input | 1 | Release a context slot this cycle |
| free_ctx | input | CTX_W | Context slot to release |
| fire_valid | output | 1 | Dispatch packet present |
| fire_ready | input | 1 | Downstream takes dispatch packet |
| fire_dyadic | output | 1 | 1 = paired two-operand packet |
| fire_ctx | output | CTX_W | Context slot |
| fire_offset | output | OFF_W | Instruction offset |
| fire_flag | output | 1 | Forwarded flag |
| fire_left | output | DATA_W | Left operand |
| fire_right | output | DATA_W | Right operand (0 for single-operand) |
| byp_valid | output | 1 | Bypass token present |
| byp_ready | input | 1 | Downstream takes bypass token |
| byp_type | output | 2 | Forwarded kind |
| byp_ctx | output | CTX_W | Forwarded ctx |
| byp_offset | output | OFF_W | Forwarded offset |
| byp_port | output | 1 | Forwarded port |
| byp_gen | output | GEN_W | Forwarded generation |
| byp_flag | output | 1 | Forwarded flag |
| byp_data | output | DATA_W | Forwarded data |
| stale_count | output | CNT_W | Saturating count of generation mismatches |
| port_err | output | 1 | One-cycle pulse on a same-port collision |

## Verification
Two cases are hard to reach from the ports. The first is a release of a context in the same cycle as a two-operand token for that context. The bench sets up that cycle by driving `free_req` and the token on one clock edge. It then proves the token survived by later supplying its partner and seeing it fire, while a leftover entry of the freed context no longer pairs. The second is reaching the top of the stale counter, which the bench does with a long run of alternating generations at one address. After that run it checks that the latest operand still pairs.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [1:0] {
    TK_DYAD = 2'b00,
    TK_MONO = 2'b01,
    TK_MEM  = 2'b10,
    TK_SYS  = 2'b11
  } tok_kind_e;
endpackage

// File: rtl/tm_classify.sv
module tm_classify (
  input  logic [1:0] kind,
  output logic       is_dyad,
  output logic       is_mono,
  output logic       is_byp
);
  always_comb begin
    is_dyad = 1'b0;
    is_mono = 1'b0;
    is_byp  = 1'b0;
    case (tm_pkg::tok_kind_e'(kind))
      tm_pkg::TK_DYAD: is_dyad = 1'b1;
      tm_pkg::TK_MONO: is_mono = 1'b1;
      default:         is_byp  = 1'b1;
    endcase
  end
endmodule

// File: rtl/tm_store.sv
module tm_store #(
  parameter int CTX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int GEN_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_en,
  input  logic [CTX_W-1:0]  tok_ctx,
  input  logic [OFF_W-1:0]  tok_off,
  input  logic              tok_port,
  input  logic [GEN_W-1:0]  tok_gen,
  input  logic [DATA_W-1:0] tok_data,
  input  logic              free_en,
  input  logic [CTX_W-1:0]  free_ctx,
  output logic              hit_fire,
  output logic              stale_hit,
  output logic              dup_hit,
  output logic [DATA_W-1:0] partner_data
);
  localparam int IDX_W = CTX_W + OFF_W;
  localparam int N     = 1 << IDX_W;

  logic [N-1:0]      ent_v;
  logic [N-1:0]      ent_p;
  logic [GEN_W-1:0]  ent_g [N];
  logic [DATA_W-1:0] ent_d [N];

  logic [IDX_W-1:0] idx;
  logic             live, gen_eq, port_eq;

  assign idx          = {tok_ctx, tok_off};
  assign live         = ent_v[idx] && !(free_en && free_ctx == tok_ctx);
  assign gen_eq       = ent_g[idx] == tok_gen;
  assign port_eq      = ent_p[idx] == tok_port;
  assign hit_fire     = tok_en && live && gen_eq && !port_eq;
  assign stale_hit    = tok_en && live && !gen_eq;
  assign dup_hit      = tok_en && live && gen_eq && port_eq;
  assign partner_data = ent_d[idx];

  // valid bits: release first, then the token's own update
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_ent
      localparam logic [CTX_W-1:0] ECTX = CTX_W'(i >> OFF_W);
      localparam logic [IDX_W-1:0] EIDX = IDX_W'(i);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_v[i] <= 1'b0;
        end else begin
          if (free_en && free_ctx == ECTX) ent_v[i] <= 1'b0;
          if (tok_en && idx == EIDX)       ent_v[i] <= !hit_fire;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (tok_en && !hit_fire) begin
      ent_p[idx] <= tok_port;
      ent_g[idx] <= tok_gen;
      ent_d[idx] <= tok_data;
    end
  end
endmodule

// File: rtl/tm_outreg.sv
module tm_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)      valid <= 1'b0;
    else if (load)   valid <= 1'b1;
    else if (ready)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end
endmodule

// File: rtl/token_matcher.sv
module token_matcher #(
  parameter int CTX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int GEN_W  = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_type,
  input  logic [CTX_W-1:0]  in_ctx,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic              in_port,
  input  logic [GEN_W-1:0]  in_gen,
  input  logic              in_flag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              free_req,
  input  logic [CTX_W-1:0]  free_ctx,
  output logic              fire_valid,
  input  logic              fire_ready,
  output logic              fire_dyadic,
  output logic [CTX_W-1:0]  fire_ctx,
  output logic [OFF_W-1:0]  fire_offset,
  output logic              fire_flag,
  output logic [DATA_W-1:0] fire_left,
  output logic [DATA_W-1:0] fire_right,
  output logic              byp_valid,
  input  logic              byp_ready,
  output logic [1:0]        byp_type,
  output logic [CTX_W-1:0]  byp_ctx,
  output logic [OFF_W-1:0]  byp_offset,
  output logic              byp_port,
  output logic [GEN_W-1:0]  byp_gen,
  output logic              byp_flag,
  output logic [DATA_W-1:0] byp_data,
  output logic [CNT_W-1:0]  stale_count,
  output logic              port_err
);
  localparam int FIRE_W = 2 + CTX_W + OFF_W + 2 * DATA_W;
  localparam int BYP_W  = 4 + CTX_W + OFF_W + GEN_W + DATA_W;

  logic acc, is_dyad, is_mono, is_byp;
  logic hit_fire, stale_hit, dup_hit;
  logic [DATA_W-1:0] partner;
  logic [DATA_W-1:0] left_w, right_w;
  logic [FIRE_W-1:0] fire_din, fire_dout;
  logic [BYP_W-1:0]  byp_din, byp_dout;

  assign in_ready = (!fire_valid || fire_ready) && (!byp_valid || byp_ready);
  assign acc      = in_valid && in_ready;

  tm_classify u_cls (
    .kind    (in_type),
    .is_dyad (is_dyad),
    .is_mono (is_mono),
    .is_byp  (is_byp)
  );

  tm_store #(
    .CTX_W (CTX_W), .OFF_W (OFF_W), .GEN_W (GEN_W), .DATA_W (DATA_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_en       (acc && is_dyad),
    .tok_ctx      (in_ctx),
    .tok_off      (in_offset),
    .tok_port     (in_port),
    .tok_gen      (in_gen),
    .tok_data     (in_data),
    .free_en      (free_req),
    .free_ctx     (free_ctx),
    .hit_fire     (hit_fire),
    .stale_hit    (stale_hit),
    .dup_hit      (dup_hit),
    .partner_data (partner)
  );

  // operand ordering by port of the arriving token
  always_comb begin
    if (is_mono) begin
      left_w  = in_data;
      right_w = '0;
    end else if (in_port) begin
      left_w  = partner;
      right_w = in_data;
    end else begin
      left_w  = in_data;
      right_w = partner;
    end
  end

  assign fire_din = {hit_fire, in_ctx, in_offset, in_flag, left_w, right_w};

  tm_outreg #(.W (FIRE_W)) u_fire (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc && (is_mono || hit_fire)),
    .din   (fire_din),
    .ready (fire_ready),
    .valid (fire_valid),
    .dout  (fire_dout)
  );

  assign {fire_dyadic, fire_ctx, fire_offset, fire_flag, fire_left, fire_right} = fire_dout;

  assign byp_din = {in_type, in_ctx, in_offset, in_port, in_gen, in_flag, in_data};

  tm_outreg #(.W (BYP_W)) u_byp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc && is_byp),
    .din   (byp_din),
    .ready (byp_ready),
    .valid (byp_valid),
    .dout  (byp_dout)
  );

  assign {byp_type, byp_ctx, byp_offset, byp_port, byp_gen, byp_flag, byp_data} = byp_dout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stale_count <= '0;
      port_err    <= 1'b0;
    end else begin
      port_err <= dup_hit;
      if (stale_hit && stale_count != {CNT_W{1'b1}})
        stale_count <= stale_count + 1'b1;
    end
  end
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int CTX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_type,
  input logic [DATA_W-1:0] in_data,
  input logic              fire_valid,
  input logic              fire_ready,
  input logic              fire_dyadic,
  input logic [CTX_W-1:0]  fire_ctx,
  input logic [OFF_W-1:0]  fire_offset,
  input logic              fire_flag,
  input logic [DATA_W-1:0] fire_left,
  input logic [DATA_W-1:0] fire_right,
  input logic              byp_valid,
  input logic              byp_ready,
  input logic [1:0]        byp_type,
  input logic [DATA_W-1:0] byp_data,
  input logic [CNT_W-1:0]  stale_count
);
  // R9
  fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid && !fire_ready |=> fire_valid &&
      $stable({fire_dyadic, fire_ctx, fire_offset, fire_flag, fire_left, fire_right}));

  // R9
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid && !byp_ready |=> byp_valid && $stable({byp_type, byp_data}));

  // R2
  mono_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_type == 2'b01 |=>
      fire_valid && !fire_dyadic && fire_left == $past(in_data) && fire_right == '0);

  // R8
  byp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_type[1] |=>
      byp_valid && byp_data == $past(in_data) && byp_type == $past(in_type));

  // R5
  stale_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stale_count >= $past(stale_count));
endmodule

bind token_matcher tm_checker #(
  .CTX_W (CTX_W), .OFF_W (OFF_W), .DATA_W (DATA_W), .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_type     (in_type),
  .in_data     (in_data),
  .fire_valid  (fire_valid),
  .fire_ready  (fire_ready),
  .fire_dyadic (fire_dyadic),
  .fire_ctx    (fire_ctx),
  .fire_offset (fire_offset),
  .fire_flag   (fire_flag),
  .fire_left   (fire_left),
  .fire_right  (fire_right),
  .byp_valid   (byp_valid),
  .byp_ready   (byp_ready),
  .byp_type    (byp_type),
  .byp_data    (byp_data),
  .stale_count (stale_count)
);

// File: tb/token_matcher_test.sv
module token_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_type = '0;
  logic [1:0]  in_ctx = '0;
  logic [2:0]  in_offset = '0;
  logic        in_port = 1'b0;
  logic [1:0]  in_gen = '0;
  logic        in_flag = 1'b0;
  logic [15:0] in_data = '0;
  logic        free_req = 1'b0;
  logic [1:0]  free_ctx = '0;
  logic        fire_valid, fire_ready = 1'b1, fire_dyadic, fire_flag;
  logic [1:0]  fire_ctx;
  logic [2:0]  fire_offset;
  logic [15:0] fire_left, fire_right;
  logic        byp_valid, byp_ready = 1'b1, byp_port, byp_flag;
  logic [1:0]  byp_type, byp_ctx, byp_gen;
  logic [2:0]  byp_offset;
  logic [15:0] byp_data;
  logic [7:0]  stale_count;
  logic        port_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  token_matcher uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [1:0] ty, input logic [1:0] c, input logic [2:0] o,
                      input logic p, input logic [1:0] g, input logic f, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_type = ty; in_ctx = c; in_offset = o;
    in_port = p; in_gen = g; in_flag = f; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic free_slot(input logic [1:0] c);
    @(negedge clk);
    free_req = 1'b1; free_ctx = c;
    @(negedge clk);
    free_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fire_valid && !byp_valid && !port_err && stale_count == 0, "R1 reset",
        {fire_valid, byp_valid, port_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 single-operand tokens
    for (int k = 0; k < 6; k++) begin
      send(2'b01, 2'(k), 3'(k + 3), 1'b0, 2'(k), 1'(k), 16'(16'h3000 + k * 37));
      chk(fire_valid && !fire_dyadic && fire_left == 16'(16'h3000 + k * 37) && fire_right == 0,
          "R2 mono data", fire_left, 16'h3000 + k * 37);
      chk(fire_ctx == 2'(k) && fire_offset == 3'(k + 3) && fire_flag == 1'(k),
          "R2 mono fields", {fire_ctx, fire_offset, fire_flag}, {2'(k), 3'(k + 3), 1'(k)});
    end

    // R3 R4 R10 R11 sweep over every address and generation
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 8; o++)
        for (int g = 0; g < 4; g++) begin
          logic [15:0] a, b;
          logic fp;
          a  = 16'((c << 8) | (o << 4) | g);
          b  = a ^ 16'hA5A5;
          fp = 1'((c + o + g) & 1);
          send(2'b00, 2'(c), 3'(o), fp, 2'(g), 1'b0, fp ? b : a);
          chk(!fire_valid, "R3 first stored", fire_valid, 0);
          send(2'b00, 2'(c), 3'(o), !fp, 2'(g), 1'(g), fp ? a : b);
          chk(fire_valid && fire_dyadic, "R11 pair fires", {fire_valid, fire_dyadic}, 3);
          chk(fire_left == a && fire_right == b, "R4 ordering", {fire_left, fire_right}, {a, b});
          chk(fire_ctx == 2'(c) && fire_offset == 3'(o), "R11 address",
              {fire_ctx, fire_offset}, {2'(c), 3'(o)});
          chk(fire_flag == 1'(g), "R10 completing flag", fire_flag, 1'(g));
        end

    // R4 entry cleared after firing
    send(2'b00, 2'd0, 3'd0, 1'b1, 2'd2, 1'b0, 16'h0B0B);
    chk(!fire_valid, "R4 cleared entry stores", fire_valid, 0);
    send(2'b00, 2'd0, 3'd0, 1'b0, 2'd2, 1'b0, 16'h0A0A);
    chk(fire_valid && fire_left == 16'h0A0A && fire_right == 16'h0B0B, "R4 refire",
        {fire_left, fire_right}, 32'h0A0A0B0B);

    // R6 same-port collision
    send(2'b00, 2'd2, 3'd5, 1'b0, 2'd1, 1'b0, 16'h1111);
    send(2'b00, 2'd2, 3'd5, 1'b0, 2'd1, 1'b0, 16'h2222);
    chk(port_err && !fire_valid, "R6 err pulse", {port_err, fire_valid}, 2);
    @(negedge clk);
    chk(!port_err, "R6 pulse one cycle", port_err, 0);
    send(2'b00, 2'd2, 3'd5, 1'b1, 2'd1, 1'b0, 16'h3333);
    chk(fire_valid && fire_left == 16'h2222 && fire_right == 16'h3333, "R6 replaced",
        {fire_left, fire_right}, 32'h22223333);

    // R7 release with a same-cycle token
    for (int o = 0; o < 8; o++) send(2'b00, 2'd1, 3'(o), 1'b0, 2'd0, 1'b0, 16'(o));
    send(2'b00, 2'd2, 3'd3, 1'b0, 2'd0, 1'b0, 16'h4444);
    @(negedge clk);
    free_req = 1'b1; free_ctx = 2'd1;
    in_valid = 1'b1; in_type = 2'b00; in_ctx = 2'd1; in_offset = 3'd4;
    in_port = 1'b1; in_gen = 2'd0; in_flag = 1'b0; in_data = 16'h5555;
    @(negedge clk);
    free_req = 1'b0; in_valid = 1'b0;
    chk(!fire_valid && !byp_valid, "R7 no output", {fire_valid, byp_valid}, 0);
    send(2'b00, 2'd1, 3'd0, 1'b1, 2'd0, 1'b0, 16'h6666);
    chk(!fire_valid, "R7 freed entry gone", fire_valid, 0);
    send(2'b00, 2'd1, 3'd4, 1'b0, 2'd0, 1'b0, 16'h7777);
    chk(fire_valid && fire_left == 16'h7777 && fire_right == 16'h5555, "R7 same-cycle token kept",
        {fire_left, fire_right}, 32'h77775555);
    send(2'b00, 2'd2, 3'd3, 1'b1, 2'd0, 1'b0, 16'h8888);
    chk(fire_valid && fire_left == 16'h4444 && fire_right == 16'h8888, "R7 other ctx kept",
        {fire_left, fire_right}, 32'h44448888);
    free_slot(2'd1);

    // R8 bypass kinds
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ty;
      ty = (k & 1) ? 2'b11 : 2'b10;
      send(ty, 2'(k), 3'(7 - k), 1'(k), 2'(k + 1), 1'(~k), 16'(16'hC000 + k));
      chk(byp_valid && !fire_valid && byp_type == ty && byp_data == 16'(16'hC000 + k),
          "R8 bypass", {byp_type, byp_data}, {ty, 16'(16'hC000 + k)});
      chk(byp_ctx == 2'(k) && byp_offset == 3'(7 - k) && byp_port == 1'(k) &&
          byp_gen == 2'(k + 1) && byp_flag == 1'(~k), "R8 fields",
          {byp_ctx, byp_offset, byp_port, byp_gen, byp_flag},
          {2'(k), 3'(7 - k), 1'(k), 2'(k + 1), 1'(~k)});
    end

    // R9 back-pressure on dispatch
    fire_ready = 1'b0;
    send(2'b01, 2'd0, 3'd1, 1'b0, 2'd0, 1'b0, 16'hAAAA);
    in_valid = 1'b1; in_type = 2'b01; in_data = 16'hBBBB;
    repeat (3) @(negedge clk);
    chk(!in_ready && fire_valid && fire_left == 16'hAAAA, "R9 held", fire_left, 16'hAAAA);
    fire_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(fire_valid && fire_left == 16'hBBBB, "R9 released", fire_left, 16'hBBBB);
    // R9 back-pressure on bypass
    byp_ready = 1'b0;
    send(2'b10, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 16'hD00D);
    @(negedge clk);
    chk(!in_ready && byp_valid && byp_data == 16'hD00D, "R9 bypass held", byp_data, 16'hD00D);
    byp_ready = 1'b1;
    @(negedge clk);
    chk(!byp_valid, "R9 bypass drained", byp_valid, 0);

    // R5 stale replacement up to saturation
    send(2'b00, 2'd3, 3'd7, 1'b0, 2'd0, 1'b0, 16'h0000);
    for (int k = 0; k < 260; k++) begin
      send(2'b00, 2'd3, 3'd7, 1'b0, 2'((k + 1) % 4), 1'b0, 16'(k + 1));
      if (k == 0 || k == 9 || k == 259) begin
        int e;
        e = (k + 1 > 255) ? 255 : k + 1;
        chk(stale_count == 8'(e) && !fire_valid, "R5 stale count", stale_count, e);
      end
    end
    send(2'b00, 2'd3, 3'd7, 1'b1, 2'd0, 1'b0, 16'hEEEE);
    chk(fire_valid && fire_left == 16'd260 && fire_right == 16'hEEEE, "R5 newest kept",
        {fire_left, fire_right}, {16'd260, 16'hEEEE});

    wrap_up();
  end
endmodule